// File: doc/BRIEF.md
# Programmable DC Offset Removal Filter

This block strips the DC component from a stream of signed ADC samples that arrive one per clock. It keeps a running estimate of the offset in a leaky accumulator. The accumulator has a fixed-point fraction. On each cycle the difference between the sample and the current estimate is scaled down by a power of two and added to the accumulator. The scale factor sets the corner of the resulting first-order high-pass response. A 4-bit code selects it. Higher codes give a lower corner and slower tracking.

The estimate feeds two consumers. One is the output sample stream. The other is the stream that goes to a power monitor. Each consumer has its own enable. When an enable is set, that stream carries the sample minus the estimate, clipped to the sample range. When it is clear, that stream carries the raw sample. A hold control stops the estimate from adapting while correction goes on with the held value. The current estimate is always visible on a readback port. One instance serves one datapath.

Top module: `dc_offset_remover`

## Requirements
- R1: While rst_ni is low, est_o, data_o and mon_o are all zero.
- R2: On each clock edge with hold_i low, the accumulator grows by (sample_i − est_o)·2^-(k+BASE_SHIFT), where k is the effective code. The accumulator holds a signed integer part of DATA_W bits over BASE_SHIFT+CODE_MAX fraction bits. est_o is the integer part, rounded toward minus infinity. It is signed two's complement.
- R3: Codes from 0 to CODE_MAX (13) take effect as given. Codes 14 and 15 behave exactly like 13.
- R4: On an edge where hold_i is high, est_o does not change.
- R5: After hold_i falls, adaptation starts again from the held estimate.
- R6: One cycle after an edge, data_o holds sat(sample_i − est_o) if out_corr_en_i was high at that edge. Otherwise it holds sample_i unchanged.
- R7: mon_o follows the same rule as data_o, but under mon_corr_en_i, independently of out_corr_en_i.
- R8: Corrected values saturate to the signed range [−512, 511] and never wrap.
- R9: Feed a constant offset plus a small zero-mean tone with correction enabled. Once the estimate has settled, the corrected output averages to within ±2 LSB of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sample_i | input | DATA_W | Signed input sample |
| code_i | input | CODE_W | Bandwidth code k; values above CODE_MAX clamp |
| hold_i | input | 1 | Freeze the offset estimate |
| out_corr_en_i | input | 1 | Apply correction to data_o |
| mon_corr_en_i | input | 1 | Apply correction to mon_o |
| data_o | output | DATA_W | Output sample path |
| mon_o | output | DATA_W | Monitor sample path |
| est_o | output | DATA_W | Current signed offset estimate |

## Verification
A corrupted accumulator shows on est_o in the same cycle as the bad update. Through the subtraction, it reaches both corrected streams one cycle later. The bench therefore compares all three outputs against an independent fixed-point model on every cycle. A clamp fault for the top codes only changes tracking by a fraction of an LSB per cycle, so it shows on est_o only after a few hundred cycles of a large input. The bench compares full estimate traces across codes 13, 14 and 15 for that reason. Faults in saturation and bypass show at once on the first sample that exercises them.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
  localparam int NUM_PATHS = 2;
  typedef enum int {
    PATH_OUT = 0,
    PATH_MON = 1
  } path_e;
endpackage

// File: rtl/dcr_shift_sel.sv
// Maps the bandwidth code to a left shift applied to the error term.
module dcr_shift_sel #(
  parameter int CODE_W   = 4,
  parameter int CODE_MAX = 13,
  parameter int SH_W     = $clog2(CODE_MAX + 1)
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [SH_W-1:0]   shamt_o
);
  always_comb begin
    if (code_i >= CODE_W'(CODE_MAX)) shamt_o = '0;
    else                             shamt_o = SH_W'(CODE_MAX) - SH_W'(code_i);
  end

  always_comb begin
    a_r3_code_clamp: assert (code_i < CODE_W'(CODE_MAX) || shamt_o == '0);
  end
endmodule

// File: rtl/dcr_estimator.sv
// Leaky accumulator; integer part is the offset estimate.
module dcr_estimator #(
  parameter int DATA_W = 10,
  parameter int FRAC_W = 27,
  parameter int SH_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] sample_i,
  input  logic [SH_W-1:0]   shamt_i,
  input  logic              hold_i,
  output logic [DATA_W-1:0] est_o
);
  localparam int ACC_W = DATA_W + FRAC_W;
  localparam int ERR_W = DATA_W + 1;

  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] delta;
  logic signed [ERR_W-1:0] err;

  assign est_o = acc_q[ACC_W-1 -: DATA_W];
  assign err   = $signed({sample_i[DATA_W-1], sample_i}) - $signed({est_o[DATA_W-1], est_o});
  // err scaled into the fraction grid: 2^-(k+base) == 2^(CODE_MAX-k) / 2^FRAC_W
  assign delta = ACC_W'(err) <<< shamt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (!hold_i) acc_q <= acc_q + delta;
  end

  a_r4_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> $stable(est_o));

  a_r2_track_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && $signed(sample_i) > $signed(est_o)) |=>
      ($signed(est_o) >= $signed($past(est_o)) && $signed(est_o) <= $signed($past(sample_i))));

  a_r2_track_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && $signed(sample_i) < $signed(est_o)) |=>
      ($signed(est_o) <= $signed($past(est_o)) && $signed(est_o) >= $signed($past(sample_i))));
endmodule

// File: rtl/dcr_apply.sv
// Subtract estimate with saturation, or pass through; registered.
module dcr_apply #(
  parameter int DATA_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] sample_i,
  input  logic [DATA_W-1:0] est_i,
  input  logic              en_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int ERR_W = DATA_W + 1;
  localparam logic signed [ERR_W-1:0] HI = ERR_W'((2 ** (DATA_W - 1)) - 1);
  localparam logic signed [ERR_W-1:0] LO = ~HI;

  logic signed [ERR_W-1:0] diff;
  logic [DATA_W-1:0]       sat;
  logic [DATA_W-1:0]       data_q;

  assign diff = $signed({sample_i[DATA_W-1], sample_i}) - $signed({est_i[DATA_W-1], est_i});

  always_comb begin
    if (diff > HI)      sat = HI[DATA_W-1:0];
    else if (diff < LO) sat = LO[DATA_W-1:0];
    else                sat = diff[DATA_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_q <= '0;
    else         data_q <= en_i ? sat : sample_i;
  end

  assign data_o = data_q;

  // R6, R7: disabled path is transparent
  a_r6_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> data_o == $past(sample_i));

  a_r8_no_wrap_pos: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !sample_i[DATA_W-1] && (est_i[DATA_W-1] || est_i == '0)) |=> !data_o[DATA_W-1]);

  a_r8_no_wrap_neg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && sample_i[DATA_W-1] && !est_i[DATA_W-1] && est_i != '0) |=> data_o[DATA_W-1]);
endmodule

// File: rtl/dc_offset_remover.sv
module dc_offset_remover
  import dcr_pkg::*;
#(
  parameter int DATA_W     = 10,
  parameter int CODE_W     = 4,
  parameter int CODE_MAX   = 13,
  parameter int BASE_SHIFT = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] sample_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              hold_i,
  input  logic              out_corr_en_i,
  input  logic              mon_corr_en_i,
  output logic [DATA_W-1:0] data_o,
  output logic [DATA_W-1:0] mon_o,
  output logic [DATA_W-1:0] est_o
);
  localparam int FRAC_W = BASE_SHIFT + CODE_MAX;
  localparam int SH_W   = $clog2(CODE_MAX + 1);

  logic [SH_W-1:0]    shamt;
  logic [DATA_W-1:0]  est;
  logic [NUM_PATHS-1:0] path_en;
  logic [DATA_W-1:0]  path_q [NUM_PATHS];

  initial begin
    a_param_code: assert (CODE_MAX < 2 ** CODE_W && BASE_SHIFT >= 1);
  end

  dcr_shift_sel #(
    .CODE_W  (CODE_W),
    .CODE_MAX(CODE_MAX),
    .SH_W    (SH_W)
  ) u_shift_sel (
    .code_i (code_i),
    .shamt_o(shamt)
  );

  dcr_estimator #(
    .DATA_W(DATA_W),
    .FRAC_W(FRAC_W),
    .SH_W  (SH_W)
  ) u_estimator (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sample_i(sample_i),
    .shamt_i (shamt),
    .hold_i  (hold_i),
    .est_o   (est)
  );

  assign path_en[PATH_OUT] = out_corr_en_i;
  assign path_en[PATH_MON] = mon_corr_en_i;

  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
    dcr_apply #(
      .DATA_W(DATA_W)
    ) u_apply (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sample_i(sample_i),
      .est_i   (est),
      .en_i    (path_en[p]),
      .data_o  (path_q[p])
    );
  end

  assign data_o = path_q[PATH_OUT];
  assign mon_o  = path_q[PATH_MON];
  assign est_o  = est;

  a_r1_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> (est_o == '0 && data_o == '0 && mon_o == '0));
endmodule

// File: tb/dc_offset_remover_bench.sv
module dc_offset_remover_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW   = 10;
  localparam int BASE = 4;
  localparam int KMAX = 13;
  localparam int FRAC = BASE + KMAX;

  typedef struct packed {
    logic signed [9:0] s;
    logic [3:0]        k;
    logic              fr;
    logic              o;
    logic              m;
    logic [7:0]        rep;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VEC [NVEC] = '{
    '{10'sd100,  4'd0, 1'b0, 1'b1, 1'b0, 8'd40},
    '{10'sd100,  4'd0, 1'b1, 1'b1, 1'b1, 8'd20},
    '{-10'sd50,  4'd0, 1'b1, 1'b0, 1'b1, 8'd10},
    '{-10'sd50,  4'd0, 1'b0, 1'b1, 1'b1, 8'd30},
    '{10'sd300,  4'd3, 1'b0, 1'b1, 1'b0, 8'd60},
    '{-10'sd300, 4'd1, 1'b0, 1'b0, 1'b1, 8'd60},
    '{10'sd7,    4'd2, 1'b0, 1'b0, 1'b0, 8'd20}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [DW-1:0] sample = '0;
  logic [3:0] kc = '0;
  logic frz = 1'b0, oe = 1'b0, me = 1'b0;
  logic [DW-1:0] data_o, mon_o, est_o;

  int n_chk = 0;
  int n_fail = 0;
  longint m_acc = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dc_offset_remover #(
    .DATA_W(DW), .CODE_W(4), .CODE_MAX(KMAX), .BASE_SHIFT(BASE)
  ) u_dc_offset_remover (
    .clk_i(clk), .rst_ni(rst_ni), .sample_i(sample), .code_i(kc), .hold_i(frz),
    .out_corr_en_i(oe), .mon_corr_en_i(me),
    .data_o(data_o), .mon_o(mon_o), .est_o(est_o)
  );

  function automatic int m_est();
    return int'(m_acc >>> FRAC);
  endfunction

  function automatic int sat(int v);
    if (v > 511) return 511;
    if (v < -512) return -512;
    return v;
  endfunction

  function automatic int tone(int i);
    case (i % 8)
      0: return 0;  1: return 6;  2: return 8;  3: return 6;
      4: return 0;  5: return -6; 6: return -8; default: return -6;
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // called just after a falling edge; returns just after the next one
  task automatic step(int s, int k, bit fr, bit o, bit m);
    int e = m_est();
    int kk = (k > KMAX) ? KMAX : k;
    int ed = o ? sat(s - e) : s;
    int em = m ? sat(s - e) : s;
    sample = DW'(s); kc = 4'(k); frz = fr; oe = o; me = m;
    if (!fr) m_acc += longint'(s - e) <<< (KMAX - kk);
    @(negedge clk);
    check("R6 data path", int'($signed(data_o)), ed);
    check("R7 monitor path", int'($signed(mon_o)), em);
    check(fr ? "R4 held estimate" : "R2 estimate update", int'($signed(est_o)), m_est());
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    m_acc = 0;
    @(negedge clk);
    check("R1 reset est", int'(est_o), 0);
    check("R1 reset data", int'(data_o), 0);
    check("R1 reset mon", int'(mon_o), 0);
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int held;
    int sum;
    int tr13 [400];
    int mism;

    do_reset();

    // table walk: R2, R4, R5, R6, R7 against the model
    for (int i = 0; i < NVEC; i++)
      for (int r = 0; r < int'(VEC[i].rep); r++)
        step(int'(VEC[i].s), int'(VEC[i].k), VEC[i].fr, VEC[i].o, VEC[i].m);

    // R4 / R5 directed
    held = int'($signed(est_o));
    for (int r = 0; r < 16; r++) step(400 - 30 * r, 0, 1'b1, 1'b1, 1'b1);
    check("R4 estimate frozen", int'($signed(est_o)), held);
    step(400, 0, 1'b0, 1'b1, 1'b1);
    check("R5 adaptation resumed", int'($signed(est_o) != DW'(held)), 1);

    // R8 saturation both ends
    do_reset();
    for (int r = 0; r < 300; r++) step(511, 0, 1'b0, 1'b1, 1'b1);
    check("R8 estimate at top", int'($signed(est_o)), 511);
    step(-512, 0, 1'b1, 1'b1, 1'b1);
    check("R8 low saturation", int'($signed(data_o)), -512);
    for (int r = 0; r < 300; r++) step(-512, 0, 1'b0, 1'b1, 1'b1);
    check("R8 estimate at bottom", int'($signed(est_o)), -512);
    step(511, 0, 1'b1, 1'b1, 1'b1);
    check("R8 high saturation", int'($signed(mon_o)), 511);

    // R3 clamp of codes 14 and 15
    do_reset();
    for (int r = 0; r < 400; r++) begin
      step(511, 13, 1'b0, 1'b1, 1'b0);
      tr13[r] = int'($signed(est_o));
    end
    check("R3 code 13 moves", int'(tr13[399] > 0), 1);
    for (int c = 14; c < 16; c++) begin
      do_reset();
      mism = 0;
      for (int r = 0; r < 400; r++) begin
        step(511, c, 1'b0, 1'b1, 1'b0);
        if (int'($signed(est_o)) != tr13[r]) mism++;
      end
      check("R3 trace matches code 13", mism, 0);
    end

    // R9 convergence with offset and tone
    do_reset();
    for (int r = 0; r < 512; r++) step(200 + tone(r), 0, 1'b0, 1'b1, 1'b1);
    sum = 0;
    for (int r = 512; r < 576; r++) begin
      step(200 + tone(r), 0, 1'b0, 1'b1, 1'b1);
      sum += int'($signed(data_o));
    end
    check("R9 mean near zero", int'(sum <= 128 && sum >= -128), 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule